// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block drives a single-wire serial output for a LIN master. A one-shot break request pulls the line low for a selectable number of bit periods and then releases it for a selectable number of bit periods. After that, the bytes that were queued go out as ordinary asynchronous frames: one start bit, eight data bits sent least significant bit first, and one stop bit. The sync byte 0x55, the identifier and any data bytes are sent this way.

Every bit boundary is taken from an external bit-rate tick that lasts one clock cycle. A single-byte holding register sits in front of the shift register. Software sees the holding-register-empty flag and the bus-idle flag, and each flag has an interrupt output that is gated by its own enable. While a break is pending or in progress, the block drops a capture-enable that it gives to a neighbouring receiver. Checksum generation, the receiver itself and any FIFO belong to other blocks.

Top module: `lin_hdr_tx`

## Requirements
- R1: A break request that is accepted arms the break on the next tick. The line is then low for 13+`brk_len` tick periods and high for 1+`dlm_len` tick periods, where `brk_len` and `dlm_len` are 2-bit codes 0..3. Both codes are latched when the request is accepted.
- R2: When `slave_mode` is 1, a break request is ignored and the line stays high.
- R3: `stat_rd` bit 0, which is the break command readback, is always 0. `stat_rd` bit 3 is 1 while a break is armed, in its low phase or in its delimiter.
- R4: A break request made while a break is active is ignored. The active break keeps its timing and its latched lengths.
- R5: `rx_capture_en` equals `rx_en` except while a break is active, when it is 0.
- R6: A byte written while a break is active is held. Its start bit begins on the tick that ends the delimiter, so no extra idle bit is added.
- R7: While `tx_en` is 0, any break or frame is aborted by the next clock edge, `txd` is 1, the holding register is empty and byte writes are dropped.
- R8: `tx_irq` is 1 exactly when `tie` is 1 and the holding register is empty (`tdr_empty`).
- R9: `bus_idle` is 1 when the holding register is empty, no frame is shifting and no break is active. `idle_irq` is `tbie` AND `bus_idle`.
- R10: A frame is 0, then data bits 0 to 7, then 1, one bit per tick. A byte held when the stop bit ends starts on that same tick, with no idle gap.
- R11: After reset, `txd`=1, `tdr_empty`=1, `bus_idle`=1 and `stat_rd`[0]=0.
- R12: A break request made while a frame is shifting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmit enable; 0 aborts and flushes |
| slave_mode | input | 1 | 1 = slave role, break requests ignored |
| rx_en | input | 1 | Receive enable from configuration |
| tie | input | 1 | Holding-empty interrupt enable |
| tbie | input | 1 | Bus-idle interrupt enable |
| brk_len | input | 2 | Break length code (13+code bits) |
| dlm_len | input | 2 | Delimiter length code (1+code bits) |
| brk_req | input | 1 | One-cycle break command strobe |
| data_we | input | 1 | Byte write strobe |
| data_in | input | 8 | Byte to send |
| txd | output | 1 | Serial line output, 1 = recessive |
| rx_capture_en | output | 1 | Receive capture permission |
| tdr_empty | output | 1 | Holding register empty |
| bus_idle | output | 1 | Transmitter fully idle |
| tx_irq | output | 1 | Holding-empty interrupt |
| idle_irq | output | 1 | Bus-idle interrupt |
| stat_rd | output | 4 | {break active, bus idle, holding empty, break cmd readback} |

## Verification
Headers are run with every break-length code and every delimiter code, each paired with a byte that has a different bit pattern: 0x55, 0xA3, 0x3C and 0x96. The waveform is compared bit by bit, so a length that is off by one or a data bit in the wrong order is detected. This also shows whether the held byte starts on the tick that ends the delimiter or one tick later. Two bytes sent back to back separate stop-bit reload from idle reload. A repeated break, a break in slave mode, a break during a frame and an abort in the middle of a frame each check that the command was ignored or took effect, through `txd` and `stat_rd`.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [1:0] {
        BG_IDLE,
        BG_ARM,
        BG_BRK,
        BG_DLM
    } brk_st_e;

endpackage

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
    import lin_hdr_pkg::*;
#(
    parameter int BRK_BASE = 13,
    parameter int DLM_BASE = 1,
    parameter int LEN_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             abort_i,
    input  logic             start_i,
    input  logic [LEN_W-1:0] brk_len_i,
    input  logic [LEN_W-1:0] dlm_len_i,
    output logic             line_low_o,
    output logic             active_o,
    output logic             release_o
);
    localparam int CNT_W = $clog2(BRK_BASE + (1 << LEN_W) + 1);

    typedef struct packed {
        brk_st_e    st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] brk_lim;
        logic [CNT_W-1:0] dlm_lim;
    } bg_t;

    bg_t q, d;

    // Last delimiter tick: the line is handed over to the byte serializer
    logic dlm_last;
    assign dlm_last = (q.st == BG_DLM) && tick_i && (q.cnt == q.dlm_lim - CNT_W'(1));

    always_comb begin
        d = q;
        if (abort_i) begin
            d.st  = BG_IDLE;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                BG_IDLE: if (start_i) begin
                    d.st      = BG_ARM;
                    d.cnt     = '0;
                    d.brk_lim = CNT_W'(BRK_BASE) + CNT_W'(brk_len_i);
                    d.dlm_lim = CNT_W'(DLM_BASE) + CNT_W'(dlm_len_i);
                end
                BG_ARM: if (tick_i) begin
                    d.st  = BG_BRK;
                    d.cnt = '0;
                end
                BG_BRK: if (tick_i) begin
                    if (q.cnt == q.brk_lim - CNT_W'(1)) begin
                        d.st  = BG_DLM;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                BG_DLM: if (tick_i) begin
                    if (dlm_last) begin
                        d.st  = BG_IDLE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: d.st = BG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: BG_IDLE, cnt: '0, brk_lim: '0, dlm_lim: '0};
        end else begin
            q <= d;
        end
    end

    assign line_low_o = (q.st == BG_BRK);
    assign active_o   = (q.st != BG_IDLE);
    assign release_o  = (q.st == BG_IDLE) || dlm_last;

    // R1: low phase never counts past its latched length
    p_brk_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BG_BRK) |-> (q.cnt < q.brk_lim));

    // R4: without a tick an active break neither advances nor restarts
    p_brk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != BG_IDLE && !tick_i && !abort_i) |=> ($stable(q.cnt) && $stable(q.brk_lim)));

endmodule

// File: rtl/lin_byte_ser.sv
module lin_byte_ser #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              abort_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              txd_o,
    output logic              busy_o,
    output logic              can_load_o
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
    } ser_t;

    ser_t q, d;

    always_comb begin
        d = q;
        if (abort_i) begin
            d.sr  = '1;
            d.cnt = '0;
        end else if (load_i) begin
            d.sr  = {1'b1, data_i, 1'b0};
            d.cnt = CNT_W'(FRAME_W);
        end else if (tick_i && q.cnt != '0) begin
            d.sr  = {1'b1, q.sr[FRAME_W-1:1]};
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sr: '1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.cnt != '0);
    assign txd_o      = busy_o ? q.sr[0] : 1'b1;
    assign can_load_o = (q.cnt <= CNT_W'(1));

    // R10: a load always opens with a start bit
    p_start_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !abort_i) |=> (!txd_o && busy_o));

    // R10: frame counter stays within one frame
    p_frame_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_W));

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
    import lin_hdr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 2,
    parameter int BRK_BASE = 13,
    parameter int DLM_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              slave_mode,
    input  logic              rx_en,
    input  logic              tie,
    input  logic              tbie,
    input  logic [LEN_W-1:0]  brk_len,
    input  logic [LEN_W-1:0]  dlm_len,
    input  logic              brk_req,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    output logic              txd,
    output logic              rx_capture_en,
    output logic              tdr_empty,
    output logic              bus_idle,
    output logic              tx_irq,
    output logic              idle_irq,
    output logic [3:0]        stat_rd
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_t;

    hold_t q, d;

    logic abort, ser_load, brk_start;
    logic brk_low, brk_active, brk_release;
    logic ser_txd, ser_busy, ser_can_load;

    assign abort     = !tx_en;
    assign ser_load  = bit_tick && tx_en && q.full && ser_can_load && brk_release;
    assign brk_start = brk_req && !slave_mode && tx_en && !brk_active
                       && !ser_busy && !ser_load;

    always_comb begin
        d = q;
        if (abort) begin
            d.full = 1'b0;
        end else begin
            if (ser_load) d.full = 1'b0;
            if (data_we) begin
                d.data = data_in;
                d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{data: '0, full: 1'b0};
        end else begin
            q <= d;
        end
    end

    lin_brk_gen #(
        .BRK_BASE (BRK_BASE),
        .DLM_BASE (DLM_BASE),
        .LEN_W    (LEN_W)
    ) u_brk (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (bit_tick),
        .abort_i    (abort),
        .start_i    (brk_start),
        .brk_len_i  (brk_len),
        .dlm_len_i  (dlm_len),
        .line_low_o (brk_low),
        .active_o   (brk_active),
        .release_o  (brk_release)
    );

    lin_byte_ser #(
        .DATA_W (DATA_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (bit_tick),
        .abort_i    (abort),
        .load_i     (ser_load),
        .data_i     (q.data),
        .txd_o      (ser_txd),
        .busy_o     (ser_busy),
        .can_load_o (ser_can_load)
    );

    assign txd           = brk_low ? 1'b0 : ser_txd;
    assign rx_capture_en = rx_en && !brk_active;
    assign tdr_empty     = !q.full;
    assign bus_idle      = !q.full && !ser_busy && !brk_active;
    assign tx_irq        = tie && tdr_empty;
    assign idle_irq      = tbie && bus_idle;
    assign stat_rd       = {brk_active, bus_idle, tdr_empty, 1'b0};

    // R7: disabling transmit leaves a released line and an empty holding register
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && tdr_empty && !brk_active));

    // R2: in slave role an idle break generator stays idle
    p_slave_ign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !brk_active) |=> !brk_active);

    // R5: a low line not caused by a frame means capture is blocked
    p_rx_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!txd && !ser_busy) |-> !rx_capture_en);

    // R6: a frame never starts while the break still owns the line
    p_load_after_brk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_busy) |-> !brk_active);

endmodule

// File: tb/lin_hdr_tx_test.sv
module lin_hdr_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick;
    logic       tx_en = 1'b1;
    logic       slave_mode = 1'b0;
    logic       rx_en = 1'b1;
    logic       tie = 1'b0;
    logic       tbie = 1'b0;
    logic [1:0] brk_len = 2'd0;
    logic [1:0] dlm_len = 2'd0;
    logic       brk_req = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       txd, rx_capture_en, tdr_empty, bus_idle, tx_irq, idle_irq;
    logic [3:0] stat_rd;
    logic [1:0] tdiv;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdiv     <= 2'd0;
            bit_tick <= 1'b0;
        end else begin
            tdiv     <= tdiv + 2'd1;
            bit_tick <= (tdiv == 2'd3);
        end
    end

    lin_hdr_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .slave_mode(slave_mode), .rx_en(rx_en), .tie(tie), .tbie(tbie),
        .brk_len(brk_len), .dlm_len(dlm_len), .brk_req(brk_req),
        .data_we(data_we), .data_in(data_in), .txd(txd),
        .rx_capture_en(rx_capture_en), .tdr_empty(tdr_empty),
        .bus_idle(bus_idle), .tx_irq(tx_irq), .idle_irq(idle_irq),
        .stat_rd(stat_rd)
    );

    // {brk_len code, dlm_len code, byte}
    localparam logic [11:0] VEC [4] = '{
        {2'd0, 2'd0, 8'h55},
        {2'd1, 2'd2, 8'hA3},
        {2'd2, 2'd1, 8'h3C},
        {2'd3, 2'd3, 8'h96}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge right after the next tick edge
    task automatic next_tick();
        while (!bit_tick) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue_break();
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        data_we = 1'b1;
        data_in = b;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    function automatic logic frame_bit(input logic [7:0] b, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return b[i-1];
        return 1'b1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 txd", txd, 1);
        chk("R11 tdr_empty", tdr_empty, 1);
        chk("R11 bus_idle", bus_idle, 1);
        chk("R11 stat_rd[0]", stat_rd[0], 0);

        // R1 / R6: header waveforms over all length codes
        foreach (VEC[v]) begin
            int nb, nd, errs, first_i;
            logic exp_b;
            logic [7:0] b;
            b = VEC[v][7:0];
            brk_len = VEC[v][11:10];
            dlm_len = VEC[v][9:8];
            nb = 13 + int'(VEC[v][11:10]);
            nd = 1 + int'(VEC[v][9:8]);
            errs = 0;
            first_i = -1;
            next_tick();
            issue_break();
            write_byte(b);
            for (int i = 0; i < nb + nd + 11; i++) begin
                next_tick();
                if (i < nb) exp_b = 1'b0;
                else if (i < nb + nd) exp_b = 1'b1;
                else if (i - nb - nd < 10) exp_b = frame_bit(b, i - nb - nd);
                else exp_b = 1'b1;
                if (txd !== exp_b) begin
                    if (first_i < 0) first_i = i;
                    errs++;
                end
            end
            if (errs != 0) $display("  header vector %0d first bad bit index %0d", v, first_i);
            chk("R1 R6 header waveform mismatching bits", errs, 0);
        end

        // R3 R5 R8 R9: flags during a break
        brk_len = 2'd0;
        dlm_len = 2'd0;
        tie = 1'b1;
        tbie = 1'b1;
        @(negedge clk);
        chk("R8 tx_irq idle", tx_irq, 1);
        chk("R9 idle_irq idle", idle_irq, 1);
        next_tick();
        issue_break();
        chk("R3 readback zero", stat_rd[0], 0);
        chk("R3 break active bit", stat_rd[3], 1);
        chk("R5 capture blocked", rx_capture_en, 0);
        chk("R9 idle_irq in break", idle_irq, 0);
        write_byte(8'h11);
        chk("R8 tx_irq with held byte", tx_irq, 0);
        for (int i = 0; i < 13 + 1 + 11; i++) next_tick();
        chk("R5 capture restored", rx_capture_en, 1);
        chk("R9 idle_irq after", idle_irq, 1);
        chk("R8 tx_irq after", tx_irq, 1);
        tie = 1'b0;
        tbie = 1'b0;

        // R2: slave role ignores break
        slave_mode = 1'b1;
        next_tick();
        issue_break();
        begin
            int lows = 0;
            for (int i = 0; i < 4; i++) begin
                next_tick();
                if (!txd) lows++;
            end
            chk("R2 slave low bits", lows, 0);
            chk("R2 slave break bit", stat_rd[3], 0);
        end
        slave_mode = 1'b0;

        // R4: repeated break keeps original length
        begin
            int lows = 0;
            int seen_high = 0;
            brk_len = 2'd0;
            dlm_len = 2'd0;
            next_tick();
            issue_break();
            for (int i = 0; i < 5; i++) begin
                next_tick();
                if (!txd) lows++;
            end
            brk_len = 2'd3;
            dlm_len = 2'd3;
            issue_break();
            for (int i = 0; i < 20; i++) begin
                next_tick();
                if (!txd && seen_high == 0) lows++;
                if (txd) seen_high = 1;
            end
            chk("R4 low bits after repeat", lows, 13);
        end
        brk_len = 2'd0;
        dlm_len = 2'd0;

        // R10 R12: back-to-back frames, break request during a frame
        begin
            int errs = 0;
            logic exp_b;
            next_tick();
            write_byte(8'hC5);
            next_tick();
            if (txd !== 1'b0) errs++;
            write_byte(8'h2B);
            issue_break();
            chk("R12 break during frame ignored", stat_rd[3], 0);
            for (int i = 1; i < 21; i++) begin
                next_tick();
                if (i < 10) exp_b = frame_bit(8'hC5, i);
                else if (i < 20) exp_b = frame_bit(8'h2B, i - 10);
                else exp_b = 1'b1;
                if (txd !== exp_b) errs++;
            end
            chk("R10 back-to-back mismatching bits", errs, 0);
        end

        // R7: abort mid frame
        next_tick();
        write_byte(8'h00);
        next_tick();
        write_byte(8'h77);
        next_tick();
        next_tick();
        tx_en = 1'b0;
        @(negedge clk);
        chk("R7 txd released", txd, 1);
        chk("R7 holding flushed", tdr_empty, 1);
        write_byte(8'h00);
        chk("R7 write dropped", tdr_empty, 1);
        tx_en = 1'b1;
        begin
            int lows = 0;
            for (int i = 0; i < 12; i++) begin
                next_tick();
                if (!txd) lows++;
            end
            chk("R7 nothing sent after re-enable", lows, 0);
            chk("R9 bus idle after abort", bus_idle, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule